// File: doc/BRIEF.md
# Word-Select Frame Start Synchronizer

This block sits in front of the serial data path of an audio serial-port slave. A slave has no control over where the frame begins, so after it is switched on it must hold off until the word-select line (WS) shows a proper frame boundary. The block samples WS on every active edge of the serial bit clock. It waits for the edge that opens a frame under the selected audio standard, then gives one start pulse and reports that the interface is running.

The Philips-style standard opens a frame on a falling WS edge. The MSB-justified, LSB-justified and PCM standards open a frame on a rising WS edge. An edge only counts when both of its levels were sampled after the interface enable was seen. When checked start is requested, the enable has to arrive while WS still sits at the level before the edge. An enable that arrives at the wrong level sets a sticky error flag, and the block still waits for the next proper edge.

Top module: `frame_start_sync`

## Requirements
- R1: While reset (`rstN` low) is asserted and directly after it is released, `startPulse`, `armed`, `running` and `frameErr` are all 0.
- R2: With `stdSel` = 0 (Philips-style), a start is issued only for a falling edge: WS sampled 1 at one bit-clock edge and 0 at the next. `startPulse` is high for the cycle after the edge that sampled the 0.
- R3: With `stdSel` = 1, 2 or 3 (MSB-justified, LSB-justified, PCM), a start is issued only for a rising edge: WS sampled 0 and then 1. A falling edge in these modes does not start the interface.
- R4: Both samples that form the edge must be taken at bit-clock edges where `ifaceEn` is 1. The first enabled edge only records WS, so no WS level seen before enable can complete an edge.
- R5: If `syncStartEn` is 1 and, at the first bit-clock edge with `ifaceEn` 1, WS is already at the post-edge level (0 for Philips-style, 1 for the others), `frameErr` becomes 1. The block stays armed and still starts on the next proper edge.
- R6: If `syncStartEn` is 0, the WS level at enable time is not checked: `frameErr` stays 0 and the first proper edge starts the interface.
- R7: `startPulse` lasts exactly one cycle. After it, `running` stays 1 while `ifaceEn` stays 1, and later WS edges give no further pulse.
- R8: A bit-clock edge that samples `ifaceEn` = 0 returns the block to idle: `armed` and `running` are 0 after that edge, and no pulse is issued.
- R9: `armed` is 1 from the first enabled edge until the start edge. `armed` and `running` are never both 1.
- R10: `frameErr` stays set until reset, even when the interface is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; its rising edge is the WS sampling edge |
| rstN | input | 1 | Asynchronous reset, active low |
| ifaceEn | input | 1 | Interface enable |
| stdSel | input | 2 | Audio standard: 0 Philips-style, 1 MSB-justified, 2 LSB-justified, 3 PCM |
| syncStartEn | input | 1 | Request to check the WS level at enable time |
| wsIn | input | 1 | Word-select line |
| startPulse | output | 1 | One-cycle pulse at the qualified frame start |
| armed | output | 1 | Enabled and waiting for the frame edge |
| running | output | 1 | Frame start seen; transfer under way |
| frameErr | output | 1 | Sticky flag: enable arrived at the post-edge WS level |

## Verification
Two cases are the hardest to reach from the ports. In the first, WS has the pre-edge level while the interface is still disabled and reaches the post-edge level in the same cycle that enable rises. This case must not start the interface. In the second, the interface is enabled on the wrong level and must still start on a later proper edge. The stimulus reaches both cases by changing `ifaceEn` and `wsIn` at the same falling clock edge. It then holds WS steady for several cycles and checks that no pulse appears before it drives a clean edge. The expected start cycle goes into a scoreboard queue, and any unplanned pulse is reported.

// File: rtl/fss_pkg.sv
package fss_pkg;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_ARMED = 2'd1,
    FS_RUN   = 2'd2
  } fsState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clear;    // drop WS history
    logic capture;  // record current WS sample
  } dpCtrl_t;

  // datapath -> control observations
  typedef struct packed {
    logic edgeHit;   // qualified frame edge on this bit-clock edge
    logic wsAtPost;  // WS currently at post-edge level
  } dpStat_t;

endpackage

// File: rtl/fss_datapath.sv
module fss_datapath
  import fss_pkg::*;
#(
  parameter int STD_W        = 2,
  parameter int PHILIPS_CODE = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wsIn,
  input  logic [STD_W-1:0] stdSel,
  input  dpCtrl_t          ctl,
  output dpStat_t          stat
);

  localparam logic [STD_W-1:0] FALL_SEL = STD_W'(PHILIPS_CODE);

  logic fallMode;
  logic preLvl;
  logic postLvl;
  logic wsSamp;
  logic histValid;

  assign fallMode = (stdSel == FALL_SEL);
  assign preLvl   = fallMode;
  assign postLvl  = ~fallMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wsSamp    <= 1'b0;
      histValid <= 1'b0;
    end else if (ctl.clear) begin
      wsSamp    <= 1'b0;
      histValid <= 1'b0;
    end else if (ctl.capture) begin
      wsSamp    <= wsIn;
      histValid <= 1'b1;
    end
  end

  always_comb begin
    stat.edgeHit  = histValid && (wsSamp == preLvl) && (wsIn == postLvl);
    stat.wsAtPost = (wsIn == postLvl);
  end

endmodule

// File: rtl/fss_control.sv
module fss_control
  import fss_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ifaceEn,
  input  logic    syncStartEn,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    startPulse,
  output logic    armed,
  output logic    running,
  output logic    frameErr
);

  fsState_t state;
  fsState_t stateNext;
  logic     pulseNext;
  logic     errSet;

  always_comb begin
    ctl.clear   = ~ifaceEn;
    ctl.capture = ifaceEn;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      FS_IDLE:  if (ifaceEn) stateNext = FS_ARMED;
      FS_ARMED: begin
        if (!ifaceEn)          stateNext = FS_IDLE;
        else if (stat.edgeHit) stateNext = FS_RUN;
      end
      FS_RUN:   if (!ifaceEn) stateNext = FS_IDLE;
      default:  stateNext = FS_IDLE;
    endcase
  end

  assign pulseNext = (state == FS_ARMED) && ifaceEn && stat.edgeHit;
  assign errSet    = (state == FS_IDLE) && ifaceEn && syncStartEn && stat.wsAtPost;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= FS_IDLE;
      startPulse <= 1'b0;
      frameErr   <= 1'b0;
    end else begin
      state      <= stateNext;
      startPulse <= pulseNext;
      if (errSet) frameErr <= 1'b1;
    end
  end

  assign armed   = (state == FS_ARMED);
  assign running = (state == FS_RUN);

endmodule

// File: rtl/frame_start_sync.sv
module frame_start_sync
  import fss_pkg::*;
#(
  parameter int STD_W        = 2,
  parameter int PHILIPS_CODE = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ifaceEn,
  input  logic [STD_W-1:0] stdSel,
  input  logic             syncStartEn,
  input  logic             wsIn,
  output logic             startPulse,
  output logic             armed,
  output logic             running,
  output logic             frameErr
);

  dpCtrl_t dpCtl;
  dpStat_t dpStat;

  fss_datapath #(
    .STD_W        (STD_W),
    .PHILIPS_CODE (PHILIPS_CODE)
  ) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .wsIn   (wsIn),
    .stdSel (stdSel),
    .ctl    (dpCtl),
    .stat   (dpStat)
  );

  fss_control i_control (
    .clk         (clk),
    .rstN        (rstN),
    .ifaceEn     (ifaceEn),
    .syncStartEn (syncStartEn),
    .stat        (dpStat),
    .ctl         (dpCtl),
    .startPulse  (startPulse),
    .armed       (armed),
    .running     (running),
    .frameErr    (frameErr)
  );

endmodule

// File: rtl/fss_checker.sv
module fss_checker #(
  parameter int STD_W        = 2,
  parameter int PHILIPS_CODE = 0
) (
  input logic             clk,
  input logic             rstN,
  input logic             ifaceEn,
  input logic [STD_W-1:0] stdSel,
  input logic             wsIn,
  input logic             startPulse,
  input logic             armed,
  input logic             running,
  input logic             frameErr
);

  localparam logic [STD_W-1:0] FALL_SEL = STD_W'(PHILIPS_CODE);

  AST_PULSE_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && $past(stdSel) == FALL_SEL) |-> ($past(wsIn, 2) && !$past(wsIn))); // R2

  AST_PULSE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && $past(stdSel) != FALL_SEL) |-> (!$past(wsIn, 2) && $past(wsIn))); // R3

  AST_PULSE_FROM_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> (running && $past(armed) && $past(ifaceEn))); // R4

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse); // R7

  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (running && ifaceEn) |=> (running && !startPulse)); // R7

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ifaceEn |=> (!armed && !running && !startPulse)); // R8

  AST_STATE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(armed && running)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> frameErr); // R10

endmodule

bind frame_start_sync fss_checker #(
  .STD_W        (STD_W),
  .PHILIPS_CODE (PHILIPS_CODE)
) i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .ifaceEn    (ifaceEn),
  .stdSel     (stdSel),
  .wsIn       (wsIn),
  .startPulse (startPulse),
  .armed      (armed),
  .running    (running),
  .frameErr   (frameErr)
);

// File: tb/test_frame_start_sync.sv
`timescale 1ns/1ps
module test_frame_start_sync;

  logic       clk = 1'b0;
  logic       rstN;
  logic       ifaceEn;
  logic [1:0] stdSel;
  logic       syncStartEn;
  logic       wsIn;
  logic       startPulse;
  logic       armed;
  logic       running;
  logic       frameErr;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int expQ[$];
  bit done   = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frame_start_sync i_frame_start_sync (
    .clk         (clk),
    .rstN        (rstN),
    .ifaceEn     (ifaceEn),
    .stdSel      (stdSel),
    .syncStartEn (syncStartEn),
    .wsIn        (wsIn),
    .startPulse  (startPulse),
    .armed       (armed),
    .running     (running),
    .frameErr    (frameErr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard: the coming posedge is expected to qualify the edge
  task automatic expectStart();
    expQ.push_back(cyc + 1);
  endtask

  // monitor: every pulse must match the next expected start cycle
  always @(negedge clk) begin
    if (rstN && startPulse) begin
      if (expQ.size() == 0) chk(1'b0, "R2/R3/R7 unexpected start pulse", cyc, -1);
      else begin
        int e;
        e = expQ.pop_front();
        chk(cyc == e, "R2/R3 start pulse cycle", cyc, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; ifaceEn = 1'b0; stdSel = 2'd0; syncStartEn = 1'b0; wsIn = 1'b0;
    tick(2);
    chk(!startPulse && !armed && !running && !frameErr, "R1 during reset",
        {startPulse, armed, running, frameErr}, 0);
    rstN = 1'b1;
    tick(1);
    chk(!startPulse && !armed && !running && !frameErr, "R1 after reset",
        {startPulse, armed, running, frameErr}, 0);

    // Philips-style, checked start, correct level
    stdSel = 2'd0; syncStartEn = 1'b1; wsIn = 1'b1; ifaceEn = 1'b1;
    tick(1);
    chk(armed && !running, "R9 armed while waiting", {armed, running}, 2);
    chk(!frameErr, "R5 no error on proper level", frameErr, 0);
    wsIn = 1'b0; expectStart();
    tick(1);
    chk(running && !armed, "R2 running after falling edge", {armed, running}, 1);
    tick(1);
    chk(!startPulse, "R7 pulse one cycle", startPulse, 0);
    // later edges do not retrigger
    for (int k = 0; k < 6; k++) begin
      wsIn = ~wsIn;
      tick(1);
    end
    chk(running, "R7 stays running", running, 1);
    ifaceEn = 1'b0;
    tick(1);
    chk(!armed && !running, "R8 disable returns idle", {armed, running}, 0);

    // rising-edge standards
    for (int s = 1; s < 4; s++) begin
      stdSel = 2'(s); syncStartEn = 1'b0; wsIn = 1'b1; ifaceEn = 1'b1;
      tick(1);
      wsIn = 1'b0;                      // falling edge: not a start here
      tick(1);
      chk(armed && !running, "R3 falling edge ignored", {armed, running}, 2);
      wsIn = 1'b1; expectStart();
      tick(1);
      chk(running, "R3 running after rising edge", running, 1);
      ifaceEn = 1'b0; wsIn = 1'b0;
      tick(1);
    end
    chk(!frameErr, "R6 no error without checked start", frameErr, 0);

    // history before enable must not form an edge (Philips-style, unchecked)
    stdSel = 2'd0; syncStartEn = 1'b0; wsIn = 1'b1;
    tick(3);
    wsIn = 1'b0; ifaceEn = 1'b1;
    tick(1);
    tick(2);
    chk(armed && !running, "R4 pre-enable level ignored", {armed, running}, 2);
    chk(!frameErr, "R6 wrong level not flagged", frameErr, 0);
    wsIn = 1'b1;
    tick(1);
    wsIn = 1'b0; expectStart();
    tick(1);
    chk(running, "R6 start on first proper edge", running, 1);
    ifaceEn = 1'b0;
    tick(1);

    // rising mode, checked start, enable at wrong level
    stdSel = 2'd3; syncStartEn = 1'b1; wsIn = 1'b1; ifaceEn = 1'b1;
    tick(1);
    chk(frameErr, "R5 error raised", frameErr, 1);
    tick(2);
    chk(armed && !running, "R5 still waiting", {armed, running}, 2);
    wsIn = 1'b0;
    tick(1);
    wsIn = 1'b1; expectStart();
    tick(1);
    chk(running, "R5 start on next proper edge", running, 1);
    ifaceEn = 1'b0;
    tick(2);
    chk(frameErr, "R10 error sticky after disable", frameErr, 1);
    chk(!running && !armed, "R8 idle after disable", {armed, running}, 0);

    rstN = 1'b0;
    tick(1);
    rstN = 1'b1;
    tick(1);
    chk(!frameErr, "R10 error cleared by reset", frameErr, 0);
    chk(expQ.size() == 0, "R2/R3 all expected starts seen", expQ.size(), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule